// File: doc/BRIEF.md
# Linked Address Compare Debug Unit

This unit decides which address-compare debug events to record for each retiring load or store. Each retiring instruction is presented for one clock with a valid strobe. Hit flags for two instruction-address comparators (A and C) and two data-address comparators (1 and 2) arrive with it, already computed. The unit reads per-comparator enables, two link controls and a flag that marks data comparator 2 as a mask or range bound. It also reads an indication that a load-multiple or store-multiple was cut short by a critical or external interrupt. From these it produces one-cycle status set pulses and a sticky status register. Software clears that register by writing ones.

Linking narrows a data event to instructions that also hit the paired instruction comparator. Data comparator 1 pairs with instruction comparator A, and data comparator 2 pairs with instruction comparator C. While a link is active, the paired instruction comparator never records its own status. The pairs are fixed by the hardware.

Top module: `link_cmp_dbg`

## Requirements
- R1: With no link active, a comparator whose hit and enable are both 1 in a valid cycle pulses its bit of `set_o`. A comparator whose enable is 0 pulses nothing. Status bit order is 0 = instruction comparator A, 1 = instruction comparator C, 2 = data comparator 1, 3 = data comparator 2.
- R2: `link_en_i[0]` pairs data comparator 1 with instruction comparator A. `link_en_i[1]` pairs data comparator 2 with instruction comparator C. A hit on the other instruction comparator neither qualifies the linked data event nor is suppressed.
- R3: With a link active, the data event (bit 2 or 3) pulses only when the same valid cycle carries the data hit, the data enable and the paired instruction hit.
- R4: With a link active, the paired instruction comparator's status bit never pulses. This holds whether the data event fires or not and whatever that instruction comparator's enable is.
- R5: While `dac2_bound_i` is 1, `link_en_i[1]` is ignored and both comparators of pair 1 behave as unlinked.
- R6: While `multi_intr_i` is 1, a linked data event does not pulse. An unlinked data event is unaffected.
- R7: Status bits are sticky. A 1 on `clr_i[n]` clears bit n at the next clock edge, and a 0 leaves it alone.
- R8: A set pulse and a clear on the same bit in the same cycle leave the bit set.
- R9: With `retire_vld_i` at 0, `set_o` is 0 and no status bit changes except by clear.
- R10: Asserting `rst_ni` low clears `sts_o` at once.
- R11: `set_o` follows the inputs in the same cycle. `sts_o` takes the pulse at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_vld_i | input | 1 | A load or store retires this cycle |
| iac_hit_i | input | 2 | Instruction comparator hits, [0]=A, [1]=C |
| iac_en_i | input | 2 | Instruction comparator enables |
| dac_hit_i | input | 2 | Data comparator hits, [0]=1, [1]=2 |
| dac_en_i | input | 2 | Data comparator enables |
| link_en_i | input | 2 | Link controls per pair |
| dac2_bound_i | input | 1 | Data comparator 2 used as mask or range bound |
| multi_intr_i | input | 1 | Multiple-word access interrupted before completion |
| clr_i | input | 4 | Write-one-to-clear strobe for status bits |
| set_o | output | 4 | Status set pulses this cycle |
| sts_o | output | 4 | Sticky status register |

## Verification
The checker assumes that a retirement's hit flags, enables, link controls and interrupt indication are valid only while `retire_vld_i` is 1 and do not change within a cycle. It also assumes that `clr_i` comes from a single write strobe lasting one cycle. The stimulus changes all inputs only on the falling clock edge and holds them for a full cycle. It drives clears as separate cycles or together with a vector, so that every rising edge sees settled values. The link-suppression properties are stated on input combinations alone, so they hold whatever values the enables take.

// File: rtl/ldbg_pkg.sv
package ldbg_pkg;
  localparam int unsigned NUM_PAIR = 2;
  localparam int unsigned STS_W    = 2 * NUM_PAIR;
  // pair whose data comparator may double as a mask/range bound
  localparam int unsigned BOUND_PAIR = 1;

  typedef enum logic [1:0] {
    STS_IAC_A = 2'd0,
    STS_IAC_C = 2'd1,
    STS_DAC_1 = 2'd2,
    STS_DAC_2 = 2'd3
  } sts_idx_e;
endpackage

// File: rtl/link_pair_eval.sv
module link_pair_eval (
  input  logic vld_i,
  input  logic iac_hit_i,
  input  logic iac_en_i,
  input  logic dac_hit_i,
  input  logic dac_en_i,
  input  logic link_req_i,
  input  logic link_ok_i,
  input  logic multi_intr_i,
  output logic iac_set_o,
  output logic dac_set_o
);
  logic linked;
  logic dac_qual;

  assign linked = link_req_i & link_ok_i;

  // linked: needs paired instruction hit, dropped on interrupted multiple
  always_comb begin
    if (linked) dac_qual = iac_hit_i & ~multi_intr_i;
    else        dac_qual = 1'b1;
  end

  assign iac_set_o = vld_i & ~linked & iac_en_i & iac_hit_i;
  assign dac_set_o = vld_i & dac_en_i & dac_hit_i & dac_qual;
endmodule

// File: rtl/link_sts_reg.sv
module link_sts_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_i) | set_i;  // set wins
  end
endmodule

// File: rtl/link_cmp_dbg.sv
module link_cmp_dbg
  import ldbg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                retire_vld_i,
  input  logic [NUM_PAIR-1:0] iac_hit_i,
  input  logic [NUM_PAIR-1:0] iac_en_i,
  input  logic [NUM_PAIR-1:0] dac_hit_i,
  input  logic [NUM_PAIR-1:0] dac_en_i,
  input  logic [NUM_PAIR-1:0] link_en_i,
  input  logic                dac2_bound_i,
  input  logic                multi_intr_i,
  input  logic [STS_W-1:0]    clr_i,
  output logic [STS_W-1:0]    set_o,
  output logic [STS_W-1:0]    sts_o
);
  logic [NUM_PAIR-1:0] link_ok;
  logic [NUM_PAIR-1:0] iac_set;
  logic [NUM_PAIR-1:0] dac_set;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    if (p == BOUND_PAIR) begin : g_bnd
      assign link_ok[p] = ~dac2_bound_i;
    end else begin : g_free
      assign link_ok[p] = 1'b1;
    end

    link_pair_eval u_eval (
      .vld_i       (retire_vld_i),
      .iac_hit_i   (iac_hit_i[p]),
      .iac_en_i    (iac_en_i[p]),
      .dac_hit_i   (dac_hit_i[p]),
      .dac_en_i    (dac_en_i[p]),
      .link_req_i  (link_en_i[p]),
      .link_ok_i   (link_ok[p]),
      .multi_intr_i(multi_intr_i),
      .iac_set_o   (iac_set[p]),
      .dac_set_o   (dac_set[p])
    );
  end

  assign set_o = {dac_set, iac_set};

  link_sts_reg #(.W(STS_W)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_o),
    .clr_i (clr_i),
    .sts_o (sts_o)
  );
endmodule

// File: rtl/link_cmp_dbg_chk.sv
module link_cmp_dbg_chk
  import ldbg_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                retire_vld_i,
  input logic [NUM_PAIR-1:0] iac_hit_i,
  input logic [NUM_PAIR-1:0] link_en_i,
  input logic                dac2_bound_i,
  input logic                multi_intr_i,
  input logic [STS_W-1:0]    clr_i,
  input logic [STS_W-1:0]    set_o,
  input logic [STS_W-1:0]    sts_o
);
  // R9
  no_vld_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_vld_i |-> (set_o == '0));

  // R4
  link_a_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_en_i[0] |-> !set_o[STS_IAC_A]);

  // R4
  link_c_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i[1] && !dac2_bound_i) |-> !set_o[STS_IAC_C]);

  // R3
  link_d1_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i[0] && !iac_hit_i[0]) |-> !set_o[STS_DAC_1]);

  // R3
  link_d2_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i[1] && !dac2_bound_i && !iac_hit_i[1]) |-> !set_o[STS_DAC_2]);

  // R6
  link_intr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i[0] && multi_intr_i) |-> !set_o[STS_DAC_1]);

  for (genvar b = 0; b < STS_W; b++) begin : g_bit
    // R8
    set_stick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_o[b] |=> sts_o[b]);
    // R7
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_o[b] && !clr_i[b]) |=> $stable(sts_o[b]));
    // R7
    clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[b] && !set_o[b]) |=> !sts_o[b]);
  end

  // R10
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      rst_zero_chk: assert (sts_o == '0);
    end
  end
endmodule

bind link_cmp_dbg link_cmp_dbg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .retire_vld_i(retire_vld_i),
  .iac_hit_i   (iac_hit_i),
  .link_en_i   (link_en_i),
  .dac2_bound_i(dac2_bound_i),
  .multi_intr_i(multi_intr_i),
  .clr_i       (clr_i),
  .set_o       (set_o),
  .sts_o       (sts_o)
);

// File: tb/link_cmp_dbg_tb_top.sv
`timescale 1ns/1ps
module link_cmp_dbg_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       retire_vld_i = 1'b0;
  logic [1:0] iac_hit_i = '0, iac_en_i = '0, dac_hit_i = '0, dac_en_i = '0, link_en_i = '0;
  logic       dac2_bound_i = 1'b0, multi_intr_i = 1'b0;
  logic [3:0] clr_i = '0;
  logic [3:0] set_o, sts_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  link_cmp_dbg dut_i (.*);

  // {iac_hit, iac_en, dac_hit, dac_en, link, bound, intr, expected set}
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    16'b11_11_11_11_00_0_0_1111, // R1 all unlinked
    16'b11_00_11_00_00_0_0_0000, // R1 enables off
    16'b01_11_00_11_00_0_0_0001, // R1 single
    16'b01_11_01_11_01_0_0_0100, // R3 R4 linked pair 0
    16'b00_11_01_11_01_0_0_0000, // R3 no paired hit
    16'b01_11_00_11_01_0_0_0000, // R4 iac only
    16'b01_00_01_01_01_0_0_0100, // R4 iac enable off
    16'b10_11_01_11_01_0_0_0010, // R2 wrong pair
    16'b10_11_10_11_10_0_0_1000, // R2 R3 linked pair 1
    16'b10_11_10_11_10_1_0_1010, // R5 bound
    16'b00_11_10_11_10_1_0_1000, // R5 bound no iac
    16'b01_11_01_11_01_0_1_0000, // R6 linked interrupted
    16'b00_11_11_11_00_0_1_1100, // R6 unlinked interrupted
    16'b11_11_11_11_11_1_1_1010, // R5 R6 mixed
    16'b11_11_11_11_11_0_0_1100, // R3 R4 both linked
    16'b01_11_01_10_01_0_0_0000  // R3 data enable off
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] v, input logic vld, input logic [3:0] clr);
    retire_vld_i = vld;
    iac_hit_i = v[15:14]; iac_en_i = v[13:12];
    dac_hit_i = v[11:10]; dac_en_i = v[9:8];
    link_en_i = v[7:6]; dac2_bound_i = v[5]; multi_intr_i = v[4];
    clr_i = clr;
  endtask

  initial begin
    #1;
    chk("R10 reset", sts_o, 4'b0000);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      drive(VEC[k], 1'b1, 4'hF);   // clear old status, new pulse wins (R8)
      #1 chk($sformatf("R%0d vec %0d set_o", (k < 3) ? 1 : 3, k), set_o, VEC[k][3:0]);
      @(posedge clk_i);
      #2 chk($sformatf("R8 vec %0d sts_o", k), sts_o, VEC[k][3:0]);
    end

    // R9: no valid strobe, no pulse
    @(negedge clk_i);
    drive(16'b11_11_11_11_00_0_0_0000, 1'b0, 4'hF);
    #1 chk("R9 set_o idle", set_o, 4'b0000);
    @(negedge clk_i);
    chk("R9 sts_o idle", sts_o, 4'b0000);

    // R11: pulse same cycle, status at next edge
    drive(16'b01_11_00_00_00_0_0_0000, 1'b1, 4'h0);
    #1 chk("R11 set_o now", set_o, 4'b0001);
    chk("R11 sts_o before edge", sts_o, 4'b0000);
    @(negedge clk_i);
    chk("R11 sts_o after edge", sts_o, 4'b0001);

    // R7: sticky, W1C per bit
    drive(16'h0000, 1'b0, 4'h0);
    repeat (3) @(negedge clk_i);
    chk("R7 sticky", sts_o, 4'b0001);
    clr_i = 4'b0010;
    @(negedge clk_i);
    chk("R7 other clear", sts_o, 4'b0001);
    clr_i = 4'b0001;
    @(negedge clk_i);
    chk("R7 clear", sts_o, 4'b0000);

    // R8: set and clear same bit
    drive(16'b00_00_10_10_00_0_0_0000, 1'b1, 4'b1000);
    @(negedge clk_i);
    chk("R8 set wins", sts_o, 4'b1000);
    drive(16'h0000, 1'b0, 4'h0);

    // R10: async reset mid-run
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1 chk("R10 async clear", sts_o, 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule